// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the line and frame timing for a parallel or 8-bit serial RGB thin-film panel. It drives HSYNC, VSYNC, data-enable, a pixel clock strobe, and the live column and line counters. Every sync window, active window and total is programmed through a small write-only register file. Each window register holds two 16-bit positions: the first position where the signal is asserted, and the first position where it is no longer asserted.

All counting happens in one clock domain, one count per clock. A write to the control register starts the generator. A second control bit requests an orderly stop: the frame in progress is finished before the outputs go idle. Timing writes go to live registers, and shadow copies pick them up only when a frame begins. A frame therefore never mixes two configurations.

In serial mode each active pixel takes three clocks, so software programs the line total in clocks. The active window is given in pixels and the hardware stretches it by three.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset, and whenever the generator is stopped, data-enable is low, both counters read 0, and HSYNC, VSYNC and the pixel strobe rest at their inactive level. The inactive level is 0, or 1 when that output's invert bit is set.
- R2: Register address 2 holds the horizontal sync window, with the start column in bits 31:16 and the end column in bits 15:0. HSYNC is asserted while start <= column < end.
- R3: Register address 3 holds the vertical sync window with the same packing, in lines. VSYNC is asserted while start <= line < end.
- R4: Address 4 holds the horizontal active window and address 5 holds the vertical active window, both packed as start/end. Data-enable is high only when the column is inside the horizontal window and the line is inside the vertical window.
- R5: Address 6 holds the clocks per line in bits 31:16 and the lines per frame in bits 15:0. The column counter wraps from total-1 to 0 and advances the line. The line counter wraps from total-1 to 0.
- R6: Writing address 0 with bit 3 set and bit 4 clear starts a stopped generator. In the first running cycle after the write edge, both counters are 0.
- R7: Writing address 0 with bit 4 set requests a regular stop, and bit 4 takes priority over bit 3. The current frame runs to its last cycle, and the generator is idle from the next cycle.
- R8: An enable write (address 0, bit 3 set, bit 4 clear) made while a stop is pending cancels the stop, and the next frame runs.
- R9: Writes to addresses 1 to 6 take effect only at the next frame start. A write on the edge that ends a frame is picked up at the frame boundary after that one.
- R10: Address 1 selects modes: bit 0 selects serial mode, bit 1 inverts the pixel strobe, bit 2 inverts HSYNC, and bit 3 inverts VSYNC.
- R11: In serial mode, data-enable spans 3*(end-start) clocks from the horizontal active start. The pixel strobe fires on columns that are a multiple of 3. In parallel mode the strobe is active on every running clock.
- R12: Out of reset the registers hold a 320x240 panel setup: sync 1 clock and 1 line, 140 clocks before and 273 after the active pixels, 20 lines before and 1 after the active lines. This gives 734 clocks per line and 262 lines per frame, with data-enable starting at column 141 of line 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register address |
| cfgData | input | 32 | Register write data |
| hsyncO | output | 1 | Horizontal sync, polarity per mode bit 2 |
| vsyncO | output | 1 | Vertical sync, polarity per mode bit 3 |
| deO | output | 1 | Data-enable, active high |
| pixClkO | output | 1 | Pixel clock strobe, polarity per mode bit 1 |
| hCountO | output | 16 | Current column (clock) counter |
| vCountO | output | 16 | Current line counter |

## Verification
Two events can fall on the same clock edge: a configuration write by software and the shadow reload at a frame boundary. The bench times a mode-register write so that it lands exactly on the edge that ends a frame. It then expects the old polarity for one more whole frame, and the new polarity only after the boundary that follows. A second collision is between a stop request and an enable written right after it within the same frame. The bench judges this by whether the next frame is produced cycle for cycle.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int REG_CTRL  = 0;
  localparam int REG_MODE  = 1;
  localparam int REG_HSYNC = 2;
  localparam int REG_VSYNC = 3;
  localparam int REG_HACT  = 4;
  localparam int REG_VACT  = 5;
  localparam int REG_TOTAL = 6;
  localparam int NUM_REGS  = 7;

  localparam int CTRL_ENABLE_BIT  = 3;
  localparam int CTRL_STOP_BIT    = 4;

  localparam int MODE_SERIAL_BIT  = 0;
  localparam int MODE_PCLK_INV    = 1;
  localparam int MODE_HS_INV      = 2;
  localparam int MODE_VS_INV      = 3;
  localparam int MODE_W           = 4;

  typedef enum logic {ST_IDLE, ST_RUN} tg_state_t;

  // control -> datapath strobes
  typedef struct packed {
    logic run;
    logic load;
    logic clear;
  } tg_strb_t;
endpackage

// File: rtl/lcd_tg_ctrl.sv
module lcd_tg_ctrl
  import lcd_tg_pkg::*;
#(
  parameter int FIELD_W  = 16,
  parameter int ADDR_W   = 3,
  parameter int H_ACTIVE = 320,
  parameter int V_ACTIVE = 240,
  parameter int H_SYNC   = 1,
  parameter int V_SYNC   = 1,
  parameter int H_BACK   = 140,
  parameter int H_FRONT  = 273,
  parameter int V_BACK   = 20,
  parameter int V_FRONT  = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [ADDR_W-1:0]    cfgAddr,
  input  logic [2*FIELD_W-1:0] cfgData,
  input  logic                 frameEnd,
  output tg_strb_t             strb,
  output logic [MODE_W-1:0]    modeLive,
  output logic [2*FIELD_W-1:0] hsLive,
  output logic [2*FIELD_W-1:0] vsLive,
  output logic [2*FIELD_W-1:0] haLive,
  output logic [2*FIELD_W-1:0] vaLive,
  output logic [2*FIELD_W-1:0] totLive
);
  localparam int DATA_W = 2 * FIELD_W;
  localparam int HA_S   = H_SYNC + H_BACK;
  localparam int VA_S   = V_SYNC + V_BACK;
  localparam int H_TOT  = H_BACK + H_ACTIVE + H_FRONT + H_SYNC;
  localparam int V_TOT  = V_SYNC + V_BACK + V_ACTIVE + V_FRONT;

  function automatic logic [DATA_W-1:0] pack2(input int hi, input int lo);
    return {FIELD_W'(hi), FIELD_W'(lo)};
  endfunction

  function automatic logic [DATA_W-1:0] resetVal(input int idx);
    case (idx)
      REG_HSYNC: return pack2(0, H_SYNC);
      REG_VSYNC: return pack2(0, V_SYNC);
      REG_HACT:  return pack2(HA_S, HA_S + H_ACTIVE);
      REG_VACT:  return pack2(VA_S, VA_S + V_ACTIVE);
      REG_TOTAL: return pack2(H_TOT, V_TOT);
      default:   return '0;
    endcase
  endfunction

  logic [DATA_W-1:0] bank [REG_MODE:NUM_REGS-1];

  for (genvar g = REG_MODE; g < NUM_REGS; g++) begin : gBank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  bank[g] <= resetVal(g);
      else if (cfgWe && cfgAddr == ADDR_W'(g))    bank[g] <= cfgData;
    end
  end

  assign modeLive = bank[REG_MODE][MODE_W-1:0];
  assign hsLive   = bank[REG_HSYNC];
  assign vsLive   = bank[REG_VSYNC];
  assign haLive   = bank[REG_HACT];
  assign vaLive   = bank[REG_VACT];
  assign totLive  = bank[REG_TOTAL];

  logic unusedModeHigh;
  assign unusedModeHigh = ^bank[REG_MODE][DATA_W-1:MODE_W];

  tg_state_t state;
  logic goPend, disPend, ctrlWr, startNow, endNow;

  assign ctrlWr   = cfgWe && cfgAddr == ADDR_W'(REG_CTRL);
  assign startNow = (state == ST_IDLE) && goPend;
  assign endNow   = (state == ST_RUN) && frameEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      goPend  <= 1'b0;
      disPend <= 1'b0;
    end else begin
      if (startNow) begin
        state  <= ST_RUN;
        goPend <= 1'b0;
      end else if (endNow && disPend) begin
        state   <= ST_IDLE;
        disPend <= 1'b0;
      end
      if (ctrlWr) begin
        if (cfgData[CTRL_STOP_BIT]) begin
          goPend <= 1'b0;
          if (state == ST_RUN) disPend <= 1'b1;
        end else if (cfgData[CTRL_ENABLE_BIT]) begin
          disPend <= 1'b0;
          if (state == ST_IDLE && !goPend) goPend <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.run   = (state == ST_RUN);
    strb.load  = startNow || (endNow && !disPend);
    strb.clear = startNow || (endNow && disPend);
  end

  // R6: a pending start is taken on the next edge
  p_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    startNow |=> state == ST_RUN);
  // R7: leaving the running state only happens on the last frame cycle
  p_stop_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !frameEnd) |=> state == ST_RUN);
  // R8: an enable write leaves no stop pending
  p_cancel_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !cfgData[CTRL_STOP_BIT] && cfgData[CTRL_ENABLE_BIT]) |=> !disPend);
endmodule

// File: rtl/lcd_tg_dp.sv
module lcd_tg_dp
  import lcd_tg_pkg::*;
#(
  parameter int FIELD_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tg_strb_t             strb,
  input  logic [MODE_W-1:0]    modeLive,
  input  logic [2*FIELD_W-1:0] hsLive,
  input  logic [2*FIELD_W-1:0] vsLive,
  input  logic [2*FIELD_W-1:0] haLive,
  input  logic [2*FIELD_W-1:0] vaLive,
  input  logic [2*FIELD_W-1:0] totLive,
  output logic                 frameEnd,
  output logic                 hsyncO,
  output logic                 vsyncO,
  output logic                 deO,
  output logic                 pixClkO,
  output logic [FIELD_W-1:0]   hCountO,
  output logic [FIELD_W-1:0]   vCountO
);
  localparam int DATA_W = 2 * FIELD_W;
  localparam int EXT_W  = FIELD_W + 2;

  logic [MODE_W-1:0] modeS;
  logic [DATA_W-1:0] hsS, vsS, haS, vaS, totS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeS <= '0;
      hsS   <= '0;
      vsS   <= '0;
      haS   <= '0;
      vaS   <= '0;
      totS  <= '0;
    end else if (strb.load) begin
      modeS <= modeLive;
      hsS   <= hsLive;
      vsS   <= vsLive;
      haS   <= haLive;
      vaS   <= vaLive;
      totS  <= totLive;
    end
  end

  logic [FIELD_W-1:0] hTot, vTot, hsBeg, hsEnd, vsBeg, vsEnd;
  logic [FIELD_W-1:0] haBeg, haEnd, vaBeg, vaEnd;
  assign {hTot, vTot}   = totS;
  assign {hsBeg, hsEnd} = hsS;
  assign {vsBeg, vsEnd} = vsS;
  assign {haBeg, haEnd} = haS;
  assign {vaBeg, vaEnd} = vaS;

  logic serial;
  assign serial = modeS[MODE_SERIAL_BIT];

  logic [FIELD_W-1:0] hCnt, vCnt;
  logic [1:0]         phase;
  logic               hLast, vLast;

  assign hLast    = (hCnt == hTot - 1'b1);
  assign vLast    = (vCnt == vTot - 1'b1);
  assign frameEnd = strb.run && hLast && vLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt  <= '0;
      vCnt  <= '0;
      phase <= '0;
    end else if (strb.clear) begin
      hCnt  <= '0;
      vCnt  <= '0;
      phase <= '0;
    end else if (strb.run) begin
      if (hLast) begin
        hCnt  <= '0;
        phase <= '0;
        vCnt  <= vLast ? '0 : vCnt + 1'b1;
      end else begin
        hCnt  <= hCnt + 1'b1;
        phase <= (serial && phase != 2'd2) ? phase + 2'd1 : 2'd0;
      end
    end
  end

  // active window end, stretched by three clocks per pixel in serial mode
  logic [EXT_W-1:0] haSpan, haEndX, hExt;
  assign haSpan = EXT_W'(haEnd) - EXT_W'(haBeg);
  assign haEndX = serial ? EXT_W'(haBeg) + (haSpan << 1) + haSpan : EXT_W'(haEnd);
  assign hExt   = EXT_W'(hCnt);

  logic inHs, inVs, inHa, inVa, pixStrb;
  assign inHs    = (hCnt >= hsBeg) && (hCnt < hsEnd);
  assign inVs    = (vCnt >= vsBeg) && (vCnt < vsEnd);
  assign inHa    = (hCnt >= haBeg) && (hExt < haEndX);
  assign inVa    = (vCnt >= vaBeg) && (vCnt < vaEnd);
  assign pixStrb = strb.run && (!serial || phase == 2'd0);

  assign hsyncO  = (strb.run && inHs) ^ modeS[MODE_HS_INV];
  assign vsyncO  = (strb.run && inVs) ^ modeS[MODE_VS_INV];
  assign deO     = strb.run && inHa && inVa;
  assign pixClkO = pixStrb ^ modeS[MODE_PCLK_INV];
  assign hCountO = hCnt;
  assign vCountO = vCnt;

  // R5: column wraps to zero after the last clock of a line
  p_hwrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && hLast) |=> hCnt == '0);
  // R5: column advances by one otherwise
  p_hstep_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.clear && !hLast) |=> hCnt == $past(hCnt) + 1'b1);
  // R1: stopped generator shows no data and zero counters
  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |-> (!deO && hCnt == '0 && vCnt == '0));
  // R11: in serial mode a strobe is never followed by another inside a line
  p_serial_gap_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && serial && pixStrb && !hLast) |=> !pixStrb);
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int FIELD_W  = 16,
  parameter int ADDR_W   = 3,
  parameter int H_ACTIVE = 320,
  parameter int V_ACTIVE = 240,
  parameter int H_SYNC   = 1,
  parameter int V_SYNC   = 1,
  parameter int H_BACK   = 140,
  parameter int H_FRONT  = 273,
  parameter int V_BACK   = 20,
  parameter int V_FRONT  = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [ADDR_W-1:0]    cfgAddr,
  input  logic [2*FIELD_W-1:0] cfgData,
  output logic                 hsyncO,
  output logic                 vsyncO,
  output logic                 deO,
  output logic                 pixClkO,
  output logic [FIELD_W-1:0]   hCountO,
  output logic [FIELD_W-1:0]   vCountO
);
  localparam int DATA_W = 2 * FIELD_W;

  tg_strb_t          strb;
  logic              frameEnd;
  logic [MODE_W-1:0] modeLive;
  logic [DATA_W-1:0] hsLive, vsLive, haLive, vaLive, totLive;

  lcd_tg_ctrl #(
    .FIELD_W(FIELD_W), .ADDR_W(ADDR_W),
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE),
    .H_SYNC(H_SYNC), .V_SYNC(V_SYNC),
    .H_BACK(H_BACK), .H_FRONT(H_FRONT),
    .V_BACK(V_BACK), .V_FRONT(V_FRONT)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .frameEnd(frameEnd), .strb(strb),
    .modeLive(modeLive), .hsLive(hsLive), .vsLive(vsLive),
    .haLive(haLive), .vaLive(vaLive), .totLive(totLive)
  );

  lcd_tg_dp #(.FIELD_W(FIELD_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .modeLive(modeLive), .hsLive(hsLive), .vsLive(vsLive),
    .haLive(haLive), .vaLive(vaLive), .totLive(totLive),
    .frameEnd(frameEnd),
    .hsyncO(hsyncO), .vsyncO(vsyncO), .deO(deO), .pixClkO(pixClkO),
    .hCountO(hCountO), .vCountO(vCountO)
  );
endmodule

// File: tb/sim_lcd_timing_gen.sv
module sim_lcd_timing_gen;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic        hsyncO, vsyncO, deO, pixClkO;
  logic [15:0] hCountO, vCountO;

  lcd_timing_gen u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .hsyncO(hsyncO), .vsyncO(vsyncO), .deO(deO), .pixClkO(pixClkO),
    .hCountO(hCountO), .vCountO(vCountO)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    int hTot, vTot, hsS, hsE, vsS, vsE, haS, haE, vaS, vaE, mode;
  } cfg_t;

  typedef struct {
    int    cyc;
    logic  hs, vs, de, pc;
    int    hc, vc;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   nChecks = 0;
  int   nFails = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic exp_t model(cfg_t c, int idx, string tag);
    exp_t e;
    int i, h, v, haEnd;
    bit serial;
    i      = idx % (c.hTot * c.vTot);
    h      = i % c.hTot;
    v      = i / c.hTot;
    serial = (c.mode & 1) != 0;
    haEnd  = serial ? c.haS + 3 * (c.haE - c.haS) : c.haE;
    e.hs   = ((h >= c.hsS) && (h < c.hsE)) ^ ((c.mode & 4) != 0);
    e.vs   = ((v >= c.vsS) && (v < c.vsE)) ^ ((c.mode & 8) != 0);
    e.de   = (h >= c.haS) && (h < haEnd) && (v >= c.vaS) && (v < c.vaE);
    e.pc   = (!serial || (h % 3) == 0) ^ ((c.mode & 2) != 0);
    e.hc   = h;
    e.vc   = v;
    e.tag  = tag;
    return e;
  endfunction

  function automatic exp_t idleOf(cfg_t c, string tag);
    exp_t e;
    e.hs = (c.mode & 4) != 0;
    e.vs = (c.mode & 8) != 0;
    e.pc = (c.mode & 2) != 0;
    e.de = 1'b0;
    e.hc = 0;
    e.vc = 0;
    e.tag = tag;
    return e;
  endfunction

  task automatic compare(exp_t e);
    nChecks++;
    if (hsyncO !== e.hs || vsyncO !== e.vs || deO !== e.de || pixClkO !== e.pc ||
        int'(hCountO) != e.hc || int'(vCountO) != e.vc) begin
      nFails++;
      $display("FAIL %s cyc %0d: got hs=%b vs=%b de=%b pc=%b h=%0d v=%0d, expected hs=%b vs=%b de=%b pc=%b h=%0d v=%0d",
               e.tag, cyc, hsyncO, vsyncO, deO, pixClkO, hCountO, vCountO,
               e.hs, e.vs, e.de, e.pc, e.hc, e.vc);
    end
  endtask

  // driver side of the scoreboard
  task automatic pushRun(cfg_t c, int startCyc, int firstIdx, int n, string tag);
    for (int j = 0; j < n; j++) begin
      exp_t e;
      e = model(c, firstIdx + j, tag);
      e.cyc = startCyc + j;
      q.push_back(e);
    end
  endtask

  task automatic pushIdle(cfg_t c, int startCyc, int n, string tag);
    for (int j = 0; j < n; j++) begin
      exp_t e;
      e = idleOf(c, tag);
      e.cyc = startCyc + j;
      q.push_back(e);
    end
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        exp_t e;
        e = q.pop_front();
        if (e.cyc < cyc) begin
          nChecks++;
          nFails++;
          $display("FAIL %s: item for cyc %0d missed (now %0d), expected compare at %0d",
                   e.tag, e.cyc, cyc, e.cyc);
        end else begin
          compare(e);
        end
      end
    end
  end

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input int a, input logic [31:0] d);
    cfgWe   = 1'b1;
    cfgAddr = 3'(a);
    cfgData = d;
    @(posedge clk);
    @(negedge clk);
    cfgWe   = 1'b0;
  endtask

  function automatic logic [31:0] pk(int hi, int lo);
    return {16'(hi), 16'(lo)};
  endfunction

  task automatic prog(cfg_t c);
    wr(1, 32'(c.mode));
    wr(2, pk(c.hsS, c.hsE));
    wr(3, pk(c.vsS, c.vsE));
    wr(4, pk(c.haS, c.haE));
    wr(5, pk(c.vaS, c.vaE));
    wr(6, pk(c.hTot, c.vTot));
  endtask

  task automatic waitUntil(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_P * 100000);
    nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    cfg_t z, d, a, b, b2, c;
    int s, L;
    z = '{hTot:1, vTot:1, hsS:0, hsE:0, vsS:0, vsE:0, haS:0, haE:0, vaS:0, vaE:0, mode:0};
    d = '{hTot:734, vTot:262, hsS:0, hsE:1, vsS:0, vsE:1, haS:141, haE:461, vaS:21, vaE:261, mode:0};
    a = '{hTot:12, vTot:7, hsS:0, hsE:2, vsS:0, vsE:1, haS:3, haE:9, vaS:2, vaE:5, mode:0};
    b = a;  b.hsS = 1; b.hsE = 3; b.haS = 4; b.haE = 8; b.mode = 14;
    b2 = b; b2.mode = 0;
    c = '{hTot:20, vTot:4, hsS:0, hsE:2, vsS:0, vsE:1, haS:3, haE:7, vaS:1, vaE:3, mode:1};

    @(negedge clk);
    doReset();
    // R1: idle after reset
    repeat (3) begin
      compare(idleOf(z, "R1"));
      @(negedge clk);
    end

    // R12 and R6: default setup, first 22 lines
    wr(0, 32'h8);
    s = cyc + 1;
    pushRun(d, s, 0, 22 * 734 + 200, "R12 R6");
    drain();

    doReset();
    compare(idleOf(z, "R1"));

    // R2 R3 R4 R5 parallel frames, R9 shadowing, R10 polarity, R7 stop
    prog(a);
    wr(0, 32'h8);
    s = cyc + 1;
    L = a.hTot * a.vTot;
    pushRun(a,  s,         0, L,     "R2 R3 R4 R5 R6");
    pushRun(b,  s + L,     0, 2 * L, "R9 R10");
    pushRun(b,  s + 3 * L, 0, L,     "R9");
    pushRun(b2, s + 4 * L, 0, L,     "R9");
    pushIdle(b2, s + 5 * L, 20, "R7");
    wr(1, 32'd14);
    wr(2, pk(1, 3));
    wr(4, pk(4, 8));
    waitUntil(s + 3 * L - 1);
    wr(1, 32'd0);            // lands on the frame-end edge
    waitUntil(s + 4 * L + 10);
    wr(0, 32'h10);
    drain();

    // R11 serial mode, R8 cancelled stop, then R7 stop
    prog(c);
    wr(0, 32'h8);
    s = cyc + 1;
    L = c.hTot * c.vTot;
    pushRun(c, s,     0, L, "R11");
    pushRun(c, s + L, 0, L, "R8 R11");
    pushIdle(c, s + 2 * L, 10, "R7");
    waitUntil(s + 20);
    wr(0, 32'h10);
    wr(0, 32'h8);
    waitUntil(s + L + 30);
    wr(0, 32'h18);           // both bits: stop wins
    drain();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule